// File: doc/BRIEF.md
# Reset Source Controller with Retention

The block turns two reset sources into two internal reset outputs and records which source caused the latest reset. The first source is an external active-low reset pin. The second is an overflow pulse from a watchdog counter. The pin is synchronized, and it is accepted only after it has stayed low for a minimum number of clock cycles. A watchdog overflow causes a reset only in one particular setting of the two watchdog mode inputs. In every other setting, the overflow raises a one-cycle interrupt request.

Two reset domains are driven. The full domain clears all system state. The retained domain covers the port direction bits, the port function-select bits, the port output levels and the oscillator-wait setting. A watchdog reset asserts only the full domain, so the retained settings survive it. A pin reset asserts both domains. Each accepted trigger holds its reset output for a fixed stretch after the trigger goes away. The 16-bit cause register is part of the retained state. It changes only when a reset is accepted: 0x0000 for the pin and 0x0001 for the watchdog.

An asynchronous power-on input acts like a pin reset. It forces both reset outputs and clears the cause to 0x0000.

Top module: `rsc_ctrl`

## Requirements
- R1: If the synchronized pin stays low for fewer than 20 consecutive cycles, nothing happens: neither reset output asserts and `rst_cause_o` keeps its value.
- R2: If the pin is driven low for N >= 20 cycles, both `full_rst_no` and `keep_rst_no` are low for exactly N-12 cycles. That is 2 cycles of synchronizer delay, 20 cycles of qualification, and 8 hold cycles after the last qualified cycle.
- R3: An accepted pin reset sets `rst_cause_o` to 0x0000.
- R4: With `wdt_int_sel_i`=0 and `wdt_rst_sel_i`=1, a one-cycle `wdt_ovf_i` pulse drives `full_rst_no` low for exactly 8 cycles, starting the cycle after the pulse. `keep_rst_no` stays high, and `rst_cause_o` becomes 0x0001.
- R5: With any other combination of the two mode inputs, an overflow causes no reset. It raises `wdt_irq_o` for one cycle, the cycle after the pulse, and `rst_cause_o` is unchanged. In the reset setting, `wdt_irq_o` never rises.
- R6: If a qualified pin reset and a watchdog reset fall in the same cycle, the pin wins. `rst_cause_o` reads 0x0000 and the retained domain is reset.
- R7: While `rst_ni` is low, both reset outputs are low and `rst_cause_o` is 0x0000. After `rst_ni` rises, both outputs are released on the 8th rising clock edge.
- R8: A single high sample of the pin restarts the low-cycle count. Two low runs of 15 cycles separated by one high cycle cause no reset.
- R9: An accepted trigger that arrives during a hold restarts the 8-cycle hold and rewrites `rst_cause_o`. `rst_cause_o` changes only in cycles where `full_rst_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_ni | input | 1 | External reset pin, asynchronous, active low |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_int_sel_i | input | 1 | Watchdog interrupt-mode bit; must be 0 for an overflow to reset |
| wdt_rst_sel_i | input | 1 | Watchdog overflow-action bit; must be 1 for an overflow to reset |
| full_rst_no | output | 1 | Full-domain reset, active low |
| keep_rst_no | output | 1 | Retained-domain reset, active low |
| wdt_irq_o | output | 1 | Watchdog interrupt request, one-cycle pulse |
| rst_cause_o | output | 16 | Cause of the latest reset: 0x0000 pin, 0x0001 watchdog |

## Verification
The hardest case to reach is two triggers landing on the very same clock edge. This needs the watchdog pulse to arrive in the last cycle of pin qualification, which sits behind a two-flop synchronizer and a 20-cycle counter. The bench drives the pin and the overflow from one loop indexed by cycle and computes that edge from the latencies. It then shifts the pulse one cycle later to show the difference: status 0x0000 with an 18-cycle reset in the first run, against status 0x0001 with a 19-cycle full reset and an 18-cycle retained reset in the second. Glitched pin pulses and pulses one cycle short of the limit cover the qualification boundary.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  parameter int unsigned RSC_STAT_W = 16;
  typedef logic [RSC_STAT_W-1:0] rsc_stat_t;
  localparam rsc_stat_t RSC_CAUSE_PIN = rsc_stat_t'(0);
  localparam rsc_stat_t RSC_CAUSE_WDT = rsc_stat_t'(1);
endpackage

// File: rtl/rsc_pin_qual.sv
module rsc_pin_qual #(
  parameter int unsigned MIN_LOW = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      low_cnt_q <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_ni};
      if (sync_q[1])                            low_cnt_q <= '0;
      else if (low_cnt_q != CW'(MIN_LOW))       low_cnt_q <= low_cnt_q + CW'(1);
    end
  end

  assign qual_o = (low_cnt_q == CW'(MIN_LOW));
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // power-on counts as a trigger: start busy with a full hold loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(HOLD);
      busy_q <= 1'b1;
    end else if (trig_i) begin
      cnt_q  <= CW'(HOLD);
      busy_q <= 1'b1;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      busy_q <= (cnt_q > CW'(1));
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/rsc_wdt_gate.sv
module rsc_wdt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic int_sel_i,
  input  logic rst_sel_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic rst_mode;
  logic irq_q;

  assign rst_mode  = !int_sel_i && rst_sel_i;
  assign rst_req_o = ovf_i && rst_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ovf_i && !rst_mode;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned MIN_LOW = 20,
  parameter int unsigned HOLD    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pin_rst_ni,
  input  logic                  wdt_ovf_i,
  input  logic                  wdt_int_sel_i,
  input  logic                  wdt_rst_sel_i,
  output logic                  full_rst_no,
  output logic                  keep_rst_no,
  output logic                  wdt_irq_o,
  output logic [RSC_STAT_W-1:0] rst_cause_o
);
  localparam int unsigned N_DOM = 2;  // 0: full, 1: retained

  logic      pin_qual;
  logic      wdt_req;
  logic      any_trig;
  rsc_stat_t cause_q;
  logic [N_DOM-1:0] dom_trig;
  logic [N_DOM-1:0] dom_busy;

  rsc_pin_qual #(.MIN_LOW(MIN_LOW)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (pin_rst_ni),
    .qual_o (pin_qual)
  );

  rsc_wdt_gate u_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_i     (wdt_ovf_i),
    .int_sel_i (wdt_int_sel_i),
    .rst_sel_i (wdt_rst_sel_i),
    .rst_req_o (wdt_req),
    .irq_o     (wdt_irq_o)
  );

  assign any_trig    = pin_qual || wdt_req;
  assign dom_trig[0] = any_trig;
  assign dom_trig[1] = pin_qual;  // retained state survives a watchdog reset

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    rsc_stretch #(.HOLD(HOLD)) u_str (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (dom_trig[d]),
      .busy_o (dom_busy[d])
    );
  end

  // cause register lives in the retained domain; written only on acceptance, pin first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= RSC_CAUSE_PIN;
    else if (pin_qual) cause_q <= RSC_CAUSE_PIN;
    else if (wdt_req)  cause_q <= RSC_CAUSE_WDT;
  end

  assign full_rst_no = !dom_busy[0];
  assign keep_rst_no = !dom_busy[1];
  assign rst_cause_o = cause_q;
endmodule

// File: rtl/rsc_ctrl_chk.sv
module rsc_ctrl_chk
  import rsc_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pin_rst_ni,
  input logic                  wdt_ovf_i,
  input logic                  wdt_int_sel_i,
  input logic                  wdt_rst_sel_i,
  input logic                  full_rst_no,
  input logic                  keep_rst_no,
  input logic                  wdt_irq_o,
  input logic [RSC_STAT_W-1:0] rst_cause_o
);
  logic rst_mode;
  assign rst_mode = !wdt_int_sel_i && wdt_rst_sel_i;

  assert_keep_within_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_rst_no |-> !full_rst_no);

  assert_pin_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(keep_rst_no) |-> rst_cause_o == RSC_CAUSE_PIN);

  assert_wdt_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(full_rst_no) && keep_rst_no) |-> rst_cause_o == RSC_CAUSE_WDT);

  assert_wdt_resets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_ovf_i && rst_mode) |=> !full_rst_no);

  assert_no_irq_in_rst_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_ovf_i && rst_mode) |=> !wdt_irq_o);

  assert_irq_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_irq_o) |-> ($past(wdt_ovf_i) && !$past(rst_mode)));

  assert_cause_only_in_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_cause_o) |-> !full_rst_no);

  assert_cause_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_cause_o == RSC_CAUSE_PIN) || (rst_cause_o == RSC_CAUSE_WDT));
endmodule

bind rsc_ctrl rsc_ctrl_chk u_chk (.*);

// File: tb/rsc_ctrl_test.sv
module rsc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_n = 1'b1;
  logic        ovf = 1'b0;
  logic        int_sel = 1'b1;
  logic        rst_sel = 1'b0;
  logic        full_n, keep_n, irq;
  logic [15:0] cause;

  int checks = 0, fails = 0;
  int n_full = 0, n_keep = 0, n_irq = 0;
  int s_full, s_keep, s_irq;
  int cyc = 0;

  always #5 clk = ~clk;

  rsc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_rst_ni(pin_n), .wdt_ovf_i(ovf),
    .wdt_int_sel_i(int_sel), .wdt_rst_sel_i(rst_sel),
    .full_rst_no(full_n), .keep_rst_no(keep_n), .wdt_irq_o(irq), .rst_cause_o(cause)
  );

  // {int_sel, rst_sel, full low cycles, irq cycles, cause after}
  typedef struct packed { logic i; logic r; int unsigned nf; int unsigned ni; logic [15:0] c; } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b1, 8, 0, 16'h0001},
    '{1'b0, 1'b0, 0, 1, 16'h0001},
    '{1'b1, 1'b1, 0, 1, 16'h0001},
    '{1'b1, 1'b0, 0, 1, 16'h0001}
  };

  always @(negedge clk) begin
    cyc    <= cyc + 1;
    n_full <= n_full + int'(!full_n);
    n_keep <= n_keep + int'(!keep_n);
    n_irq  <= n_irq + int'(irq);
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mark();
    @(posedge clk);
    s_full = n_full; s_keep = n_keep; s_irq = n_irq;
  endtask

  task automatic measure(input string tag, input int ef, input int ek, input int c);
    @(posedge clk);
    check({tag, " full low"}, n_full - s_full, ef);
    check({tag, " keep low"}, n_keep - s_keep, ek);
    check({tag, " cause"}, int'(cause), c);
  endtask

  // pin low l1, high gap, low l2; overflow pulse at step ovf_k (-1: none)
  task automatic pin_seq(input int l1, input int gap, input int l2, input int ovf_k);
    for (int k = 0; k < l1 + gap + l2 + 20; k++) begin
      @(negedge clk);
      pin_n = !((k < l1) || (k >= l1 + gap && k < l1 + gap + l2));
      ovf   = (k == ovf_k);
    end
  endtask

  task automatic wdt_pulse();
    @(negedge clk); ovf = 1'b1;
    @(negedge clk); ovf = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 full during por", int'(full_n), 0);
    check("R7 keep during por", int'(keep_n), 0);
    check("R7 cause during por", int'(cause), 0);
    mark();
    @(negedge clk); rst_n = 1'b1;
    repeat (15) @(negedge clk);
    measure("R7 release", 8, 8, 0);

    // watchdog mode table: R4 (reset mode), R5 (other modes)
    foreach (VECS[v]) begin
      @(negedge clk); int_sel = VECS[v].i; rst_sel = VECS[v].r;
      mark();
      wdt_pulse();
      measure($sformatf("R4_R5 vec%0d", v), int'(VECS[v].nf), 0, int'(VECS[v].c));
      check($sformatf("R5 irq vec%0d", v), n_irq - s_irq, int'(VECS[v].ni));
    end

    @(negedge clk); int_sel = 1'b0; rst_sel = 1'b1;
    mark(); pin_seq(19, 0, 0, -1); measure("R1 pin 19", 0, 0, 1);
    mark(); pin_seq(20, 0, 0, -1); measure("R2_R3 pin 20", 8, 8, 0);
    mark(); wdt_pulse();           measure("R4 after pin", 8, 0, 1);
    mark(); pin_seq(15, 1, 15, -1); measure("R8 glitch", 0, 0, 1);
    mark(); pin_seq(25, 0, 0, -1); measure("R2 pin 25", 13, 13, 0);
    mark(); wdt_pulse();           measure("R4 rearm", 8, 0, 1);
    mark(); pin_seq(30, 0, 0, 32); measure("R6 same edge", 18, 18, 0);
    mark(); pin_seq(30, 0, 0, 33); measure("R9 retrigger", 19, 18, 1);
    check("R6 irq none", n_irq - s_irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule